// File: doc/BRIEF.md
# PHY Link Speed and Duplex Resolver

This block works out the operating mode of an Ethernet link once the PHY has been brought up. On a start pulse it reads the PHY's standard management registers through a simple request/response read port. It waits, when needed, for auto-negotiation to finish, then reports whether the link is up, the speed (10, 100 or 1000 Mb/s) and whether the link runs full duplex.

When the PHY supports auto-negotiation, the mode is the best one that both ends advertise. The gigabit abilities are checked first, then the 100BASE-TX abilities, then 10 Mb/s. When the PHY cannot negotiate, the mode comes straight from the speed and duplex bits of its control register. A bounded poll loop re-reads status at a fixed interval while negotiation is still running. If the loop runs out, a timeout flag is raised and the safe 10 Mb/s half-duplex mode is reported.

Top module: `phy_mode_resolver`

## Requirements
- R1: Each run reads the status register (address 1) twice. The first value is discarded, so that a latched-low link bit is cleared. The link bit (bit 2) of a later status read drives link_up.
- R2: Link up (bit 2), negotiation able (bit 3) and negotiation complete (bit 5) clear means negotiation is still running. In that case the block waits POLL_INTERVAL cycles and reads status again, and repeats until bit 5 is set.
- R3: A status read that still shows the running condition once MAX_POLLS re-reads have been made ends the run. timed_out is set, link_up shows that read's link bit, and the mode is 10 Mb/s half duplex. A run of this kind makes MAX_POLLS+2 status reads.
- R4: The gigabit registers (control at address 9, status at address 10) are read only when status bit 0 (extended capability) and bit 3 are set. The gigabit common set is the status value ANDed with the control value shifted left by 2.
- R5: If bit 11 (1000 full) or bit 10 (1000 half) of the gigabit common set is set, the speed is 1000. The link is full duplex only when bit 11 is set.
- R6: Otherwise the common set is the local advertisement (address 4) ANDed with the partner ability (address 5). If bit 8 (100TX full) or bit 7 (100TX half) is set, the speed is 100, full duplex only with bit 8. This holds even when bit 6 is also common.
- R7: Otherwise, common bit 6 (10 full) gives 10 Mb/s full duplex. When nothing is common the mode is 10 Mb/s half duplex.
- R8: With status bit 3 clear, the block reads the control register (address 0). Bit 8 gives the duplex. The speed is 1000 if bit 6 is set, else 100 if bit 13 is set, else 10. The advertisement registers have no effect in this case.
- R9: The speed is encoded 00=10, 01=100, 10=1000. done is high for exactly one cycle when the result becomes valid. The outputs hold their values until the next result.
- R10: rd_req stays high with a stable rd_addr until rd_ack is seen, and rd_data is taken in the rd_ack cycle.
- R11: If link is down, or negotiation is not supported, or negotiation is already complete, no wait is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a resolution run |
| rd_req | output | 1 | PHY register read request |
| rd_addr | output | AW | PHY register address of the request |
| rd_ack | input | 1 | One-cycle response strobe, data valid with it |
| rd_data | input | 16 | PHY register value |
| link_up | output | 1 | Link state from the last status read |
| speed | output | 2 | Resolved speed code |
| full_duplex | output | 1 | Resolved duplex, 1 = full |
| done | output | 1 | One-cycle pulse when a result is valid |
| timed_out | output | 1 | Negotiation wait ran out on the last run |

## Verification
After the final register response, the outputs and the done pulse appear two clock edges later. There is one edge to latch the response and move to the finishing state, and one edge to register the result. The bench samples on the falling edge. It waits for done, checks every output in that cycle, and checks one cycle later that done has fallen while the result is held. The poll interval makes a waiting run take at least POLL_INTERVAL more cycles, so the bench checks elapsed cycles and the number of status reads rather than exact edges for those runs.

// File: rtl/phy_res_pkg.sv
package phy_res_pkg;
  localparam int REG_W = 16;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_ADV   = 4;
  localparam int A_LPA   = 5;
  localparam int A_GCTRL = 9;
  localparam int A_GSTAT = 10;

  // status bits
  localparam int S_EXT  = 0;
  localparam int S_LINK = 2;
  localparam int S_ABLE = 3;
  localparam int S_DONE = 5;

  // control bits
  localparam int C_S1000 = 6;
  localparam int C_FULL  = 8;
  localparam int C_S100  = 13;

  // ability bits
  localparam int B_10F   = 6;
  localparam int B_TXH   = 7;
  localparam int B_TXF   = 8;
  localparam int B_G_H   = 10;
  localparam int B_G_F   = 11;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10
  } speed_e;

  typedef struct packed {
    speed_e spd;
    logic   fd;
  } mode_t;

  function automatic mode_t mode_from_abilities(
    input logic [REG_W-1:0] gctl, input logic [REG_W-1:0] gstat,
    input logic [REG_W-1:0] adv,  input logic [REG_W-1:0] lpa);
    logic [REG_W-1:0] gcom;
    logic [REG_W-1:0] com;
    mode_t m;
    gcom = gstat & (gctl << 2);
    com  = adv & lpa;
    m.spd = SPD_10;
    m.fd  = 1'b0;
    if (gcom[B_G_F] || gcom[B_G_H]) begin
      m.spd = SPD_1000;
      m.fd  = gcom[B_G_F];
    end else if (com[B_TXF] || com[B_TXH]) begin
      m.spd = SPD_100;
      m.fd  = com[B_TXF];
    end else if (com[B_10F]) begin
      m.fd  = 1'b1;
    end
    return m;
  endfunction

  function automatic mode_t mode_from_control(input logic [REG_W-1:0] ctl);
    mode_t m;
    m.fd = ctl[C_FULL];
    if (ctl[C_S1000])     m.spd = SPD_1000;
    else if (ctl[C_S100]) m.spd = SPD_100;
    else                  m.spd = SPD_10;
    return m;
  endfunction
endpackage

// File: rtl/prs_wait_timer.sv
module prs_wait_timer #(
  parameter int INTERVAL = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/prs_mode_pick.sv
module prs_mode_pick
  import phy_res_pkg::*;
(
  input  logic             aneg,
  input  logic [REG_W-1:0] ctl,
  input  logic [REG_W-1:0] adv,
  input  logic [REG_W-1:0] lpa,
  input  logic [REG_W-1:0] gctl,
  input  logic [REG_W-1:0] gstat,
  output mode_t            mode
);
  always_comb begin
    if (aneg) mode = mode_from_abilities(gctl, gstat, adv, lpa);
    else      mode = mode_from_control(ctl);
  end
endmodule

// File: rtl/phy_mode_resolver.sv
module phy_mode_resolver
  import phy_res_pkg::*;
#(
  parameter int POLL_INTERVAL = 100000,
  parameter int MAX_POLLS     = 1000,
  parameter int AW            = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  output logic          link_up,
  output logic [1:0]    speed,
  output logic          full_duplex,
  output logic          done,
  output logic          timed_out
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LIM = PW'(MAX_POLLS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_STAT0, ST_STAT1, ST_WAIT, ST_GSTAT,
    ST_GCTL, ST_ADV, ST_LPA, ST_CTRL, ST_FIN
  } state_e;

  state_e st_q, st_d;
  logic [REG_W-1:0] stat_q, ctl_q, adv_q, lpa_q, gctl_q, gstat_q;
  logic [PW-1:0]    poll_q;
  logic             to_q;
  mode_t            picked;

  // named events for the checker
  logic wait_needed, poll_fire, to_evt, result_load, stat_take;

  assign stat_take   = (st_q == ST_STAT1) && rd_ack;
  assign wait_needed = rd_data[S_LINK] && rd_data[S_ABLE] && !rd_data[S_DONE];
  assign to_evt      = stat_take && wait_needed && (poll_q == POLL_LIM);
  assign result_load = (st_q == ST_FIN);

  prs_wait_timer #(.INTERVAL(POLL_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_WAIT), .expire(poll_fire)
  );

  prs_mode_pick u_pick (
    .aneg(stat_q[S_ABLE]), .ctl(ctl_q), .adv(adv_q), .lpa(lpa_q),
    .gctl(gctl_q), .gstat(gstat_q), .mode(picked)
  );

  always_comb begin
    rd_req  = 1'b1;
    rd_addr = AW'(A_STAT);
    unique case (st_q)
      ST_STAT0, ST_STAT1: rd_addr = AW'(A_STAT);
      ST_GSTAT:           rd_addr = AW'(A_GSTAT);
      ST_GCTL:            rd_addr = AW'(A_GCTRL);
      ST_ADV:             rd_addr = AW'(A_ADV);
      ST_LPA:             rd_addr = AW'(A_LPA);
      ST_CTRL:            rd_addr = AW'(A_CTRL);
      default:            rd_req  = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_STAT0;
      ST_STAT0: if (rd_ack) st_d = ST_STAT1;
      ST_STAT1: if (rd_ack) begin
        if (wait_needed)            st_d = to_evt ? ST_FIN : ST_WAIT;
        else if (!rd_data[S_ABLE])  st_d = ST_CTRL;
        else if (rd_data[S_EXT])    st_d = ST_GSTAT;
        else                        st_d = ST_ADV;
      end
      ST_WAIT:  if (poll_fire) st_d = ST_STAT1;
      ST_GSTAT: if (rd_ack) st_d = ST_GCTL;
      ST_GCTL:  if (rd_ack) st_d = ST_ADV;
      ST_ADV:   if (rd_ack) st_d = ST_LPA;
      ST_LPA:   if (rd_ack) st_d = ST_FIN;
      ST_CTRL:  if (rd_ack) st_d = ST_FIN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      stat_q <= '0; ctl_q <= '0; adv_q <= '0;
      lpa_q <= '0; gctl_q <= '0; gstat_q <= '0;
      poll_q <= '0; to_q <= 1'b0;
      link_up <= 1'b0; speed <= SPD_10; full_duplex <= 1'b0;
      done <= 1'b0; timed_out <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= result_load;
      if (st_q == ST_IDLE && start) begin
        stat_q <= '0; ctl_q <= '0; adv_q <= '0;
        lpa_q <= '0; gctl_q <= '0; gstat_q <= '0;
        poll_q <= '0; to_q <= 1'b0;
      end
      if (stat_take)                 stat_q  <= rd_data;
      if (to_evt)                    to_q    <= 1'b1;
      if (poll_fire)                 poll_q  <= poll_q + 1'b1;
      if (st_q == ST_GSTAT && rd_ack) gstat_q <= rd_data;
      if (st_q == ST_GCTL && rd_ack)  gctl_q  <= rd_data;
      if (st_q == ST_ADV && rd_ack)   adv_q   <= rd_data;
      if (st_q == ST_LPA && rd_ack)   lpa_q   <= rd_data;
      if (st_q == ST_CTRL && rd_ack)  ctl_q   <= rd_data;
      if (result_load) begin
        link_up   <= stat_q[S_LINK];
        timed_out <= to_q;
        if (to_q) begin
          speed       <= SPD_10;
          full_duplex <= 1'b0;
        end else begin
          speed       <= picked.spd;
          full_duplex <= picked.fd;
        end
      end
    end
  end
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          done,
  input logic          timed_out,
  input logic [1:0]    speed,
  input logic          full_duplex,
  input logic          poll_fire,
  input logic          to_evt,
  input logic          stat_take,
  input logic          wait_needed
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  speed_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (speed != 2'b11 && !rd_req));

  // R2
  poll_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fire |=> (rd_req && rd_addr == AW'(1)));

  // R3
  timeout_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> ##2 (done && timed_out && speed == 2'b00 && !full_duplex));

  // R11
  no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_take && !wait_needed) |=> !poll_fire);
endmodule

bind phy_mode_resolver prs_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .done(done), .timed_out(timed_out), .speed(speed),
  .full_duplex(full_duplex), .poll_fire(poll_fire), .to_evt(to_evt),
  .stat_take(stat_take), .wait_needed(wait_needed)
);

// File: tb/sim_phy_mode_resolver.sv
module sim_phy_mode_resolver;
  localparam int INTV  = 16;
  localparam int POLLS = 4;
  localparam int NV    = 14;

  typedef struct packed {
    logic [15:0] ctl, stat, adv, lpa, gctl, gstat, comp;
    logic        link;
    logic [1:0]  spd;
    logic        fd, to;
  } vec_t;

  // comp: status reads numbered above this show negotiation complete
  localparam vec_t VECS [NV] = '{
    '{16'h0000,16'h000D,16'h01E0,16'h01E0,16'h0300,16'h0C00,16'd0,   1'b1,2'd2,1'b1,1'b0},
    '{16'h0000,16'h000D,16'h01E0,16'h01E0,16'h0100,16'h0C00,16'd0,   1'b1,2'd2,1'b0,1'b0},
    '{16'h0000,16'h000D,16'h01E0,16'h01E0,16'h0200,16'h0400,16'd0,   1'b1,2'd1,1'b1,1'b0},
    '{16'h0000,16'h000C,16'h0180,16'h0080,16'h0300,16'h0C00,16'd0,   1'b1,2'd1,1'b0,1'b0},
    '{16'h0000,16'h000C,16'h00C0,16'h00C0,16'h0000,16'h0000,16'd0,   1'b1,2'd1,1'b0,1'b0},
    '{16'h0000,16'h000C,16'h0060,16'h0040,16'h0000,16'h0000,16'd0,   1'b1,2'd0,1'b1,1'b0},
    '{16'h0000,16'h000C,16'h0040,16'h0020,16'h0000,16'h0000,16'd0,   1'b1,2'd0,1'b0,1'b0},
    '{16'h0140,16'h0004,16'h01E0,16'h01E0,16'h0300,16'h0C00,16'd0,   1'b1,2'd2,1'b1,1'b0},
    '{16'h2000,16'h0004,16'h0000,16'h0000,16'h0000,16'h0000,16'd0,   1'b1,2'd1,1'b0,1'b0},
    '{16'h2040,16'h0004,16'h0000,16'h0000,16'h0000,16'h0000,16'd0,   1'b1,2'd2,1'b0,1'b0},
    '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'd0,   1'b0,2'd0,1'b0,1'b0},
    '{16'h0000,16'h000D,16'h01E0,16'h01E0,16'h0300,16'h0C00,16'd2,   1'b1,2'd2,1'b1,1'b0},
    '{16'h0000,16'h000D,16'h01E0,16'h01E0,16'h0300,16'h0C00,16'd1000,1'b1,2'd0,1'b0,1'b1},
    '{16'h0000,16'h0008,16'h0100,16'h0100,16'h0000,16'h0000,16'd1000,1'b0,2'd1,1'b1,1'b0}
  };
  localparam string TAGS [NV] = '{
    "R5", "R5", "R4", "R4", "R6", "R7", "R7",
    "R8", "R8", "R8", "R8", "R2", "R3", "R11"
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_req, rd_ack, link_up, full_duplex, done, timed_out;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  speed;
  int checks = 0, errors = 0;

  logic [15:0] m_ctl, m_stat, m_adv, m_lpa, m_gctl, m_gstat;
  int comp_after = 0, st_reads, g_reads, drops;

  always #5 clk = ~clk;

  phy_mode_resolver #(.POLL_INTERVAL(INTV), .MAX_POLLS(POLLS), .AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .link_up(link_up), .speed(speed), .full_duplex(full_duplex),
    .done(done), .timed_out(timed_out)
  );

  // PHY register model, one-cycle response, latched-low link on first read
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0; rd_data <= '0;
      st_reads <= 0; g_reads <= 0; drops <= 0;
    end else begin
      if (start) begin st_reads <= 0; g_reads <= 0; end
      if (rd_ack && !rd_req) drops <= drops + 1;
      rd_ack <= rd_req && !rd_ack;
      if (rd_req && !rd_ack) begin
        case (rd_addr)
          5'd0:  rd_data <= m_ctl;
          5'd1: begin
            rd_data <= (m_stat & ((st_reads == 0) ? 16'hFFFB : 16'hFFFF)) |
                       ((st_reads + 1 > comp_after) ? 16'h0020 : 16'h0000);
            st_reads <= st_reads + 1;
          end
          5'd4:  rd_data <= m_adv;
          5'd5:  rd_data <= m_lpa;
          5'd9:  begin rd_data <= m_gctl;  g_reads <= g_reads + 1; end
          5'd10: begin rd_data <= m_gstat; g_reads <= g_reads + 1; end
          default: rd_data <= 16'hDEAD;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, output int cyc);
    m_ctl = v.ctl; m_stat = v.stat; m_adv = v.adv; m_lpa = v.lpa;
    m_gctl = v.gctl; m_gstat = v.gstat; comp_after = int'(v.comp);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(tag, "done seen", int'(done), 1);
    chk({tag, "/R1"}, "link_up", int'(link_up), int'(v.link));
    chk(tag, "speed code", int'(speed), int'(v.spd));
    chk(tag, "full_duplex", int'(full_duplex), int'(v.fd));
    chk(tag, "timed_out", int'(timed_out), int'(v.to));
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    chk("R9", "speed held", int'(speed), int'(v.spd));
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    m_ctl = 0; m_stat = 0; m_adv = 0; m_lpa = 0; m_gctl = 0; m_gstat = 0;
    repeat (3) @(negedge clk);
    // reset state, R9
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset speed", int'(speed), 0);
    chk("R9", "reset link", int'(link_up), 0);
    chk("R10", "reset rd_req", int'(rd_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], TAGS[i], cyc);
      if (i == 0)  chk("R1", "status reads", st_reads, 2);
      if (i == 3)  chk("R4", "gigabit reads without ext", g_reads, 0);
      if (i == 0)  chk("R4", "gigabit reads with ext", g_reads, 2);
      if (i == 11) begin
        chk("R2", "status reads one poll", st_reads, 3);
        chk("R2", "wait at least interval", int'(cyc >= INTV), 1);
      end
      if (i == 12) chk("R3", "status reads on timeout", st_reads, POLLS + 2);
      if (i == 13) chk("R11", "no poll when link down", st_reads, 2);
    end
    // no start: result held, no request
    repeat (20) @(negedge clk);
    chk("R9", "idle holds speed", int'(speed), 1);
    chk("R10", "idle no request", int'(rd_req), 0);
    chk("R10", "ack without request", drops, 0);
    // a run after timeout clears the flag
    run_vec(VECS[6], "R3", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule